// File: doc/BRIEF.md
# Ethernet receive frame status classifier

This block sits beside a nibble-wide media-independent receive interface and observes one frame at a time. It strips the preamble, assembles data nibbles into bytes (low nibble first), counts the bytes, runs a CRC-32 over them and captures the two-byte length/type field. It also records the error conditions seen while the frame arrives. The data stream itself is never altered, truncated or dropped. The block only observes it.

When receive data valid drops at the end of a frame, the block reports a one-byte summary of that frame together with a strobe that lasts one clock. The flags interact. A short frame cannot claim a type. A receive error forces the CRC flag. A late collision hides dribble bits. The CRC flag is withheld whenever the frame is too short, collided late or ran past the watchdog.

Top module: `rx_frame_classifier`

## Requirements
- R1: `stat_valid` is high for exactly one cycle. That cycle is the one after the first rising clock edge at which `mii_dv` is sampled low following a frame. `stat_byte` holds the summary: [7] oversize, [6] late collision, [5] typed frame, [4] watchdog, [3] receive error, [2] dribble, [1] CRC error. Bit [0] is always 0.
- R2: Bit 7 is set when the frame holds more than 1518 bytes after the delimiter, counting the FCS. Counting continues past that size.
- R3: Bit 6 is set when `mii_col` is high during a data nibble that arrives after 64 or more whole bytes have been received. A collision inside the first 64 bytes has no effect.
- R4: Bit 5 is set when the 16-bit value {byte 12, byte 13} is greater than 1500. Bytes are numbered from 0 at the destination address. The bit is never set when fewer than 14 bytes arrived.
- R5: Bit 4 is set when more than 2048 bytes arrived.
- R6: Bit 3 is set when `mii_er` is high in any cycle with `mii_dv` high, preamble included.
- R7: Bit 2 is set when one leftover nibble (4 bits) follows the last whole byte. It is never set together with bit 6. The leftover nibble does not enter the CRC.
- R8: The CRC uses polynomial 0x04C11DB7, bit-reflected, with an all-ones start, over every whole byte including the FCS. The frame passes when the residue equals 0xC704DD7B (0xDEBB20E3 in reflected form). The FCS is sent least significant byte first.
- R9: Bit 1 is set by a failed CRC, or by any receive error during the frame even when the CRC passes.
- R10: Bit 1 is forced to 0 when fewer than 64 bytes arrived, when bit 6 is set, or when bit 4 is set.
- R11: All flags, counters, the CRC and the captured field restart at each new frame. Nothing carries over from the previous frame.
- R12: Data begins after the first nibble 0xD seen while `mii_dv` is high. The preamble length does not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_dv | input | 1 | Receive data valid |
| mii_er | input | 1 | Receive error |
| mii_col | input | 1 | Collision indication |
| mii_rxd | input | 4 | Receive nibble, low nibble of each byte first |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_byte | output | 8 | Frame status summary |

## Verification
The hardest conditions to reach are the limits on frame length. One is the boundary of the collision window: a collision on nibble 127 must be ignored, while a collision on nibble 128 counts as late. The other is the watchdog, at 2048 bytes and at 2049. The bench builds every frame in a byte buffer and appends a real FCS, so the CRC passes unless a test flips one bit. It places collision and error pulses on exact nibble indices, so these boundaries can be hit on purpose. Frames of 2048 and 2049 bytes, both with a corrupted FCS, show that the watchdog hides the CRC flag.

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier #(
  parameter int CNT_W     = 16,
  parameter int MAX_LEN   = 1518,
  parameter int WDOG_LEN  = 2048,
  parameter int SLOT      = 64,
  parameter int MIN_FRAME = 64,
  parameter int HDR_MIN   = 14,
  parameter int TYPE_MAX  = 1500,
  parameter int LT_POS    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mii_dv,
  input  logic       mii_er,
  input  logic       mii_col,
  input  logic [3:0] mii_rxd,
  output logic       stat_valid,
  output logic [7:0] stat_byte
);
  localparam logic [3:0]  SFD_NIB = 4'hD;
  localparam logic [31:0] POLY_R  = 32'hEDB88320;
  localparam logic [31:0] RESIDUE = 32'hDEBB20E3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic [15:0]      lt;
  logic [3:0]       lo;
  logic             half, er_seen, late;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY_R) : (r >> 1);
    return r;
  endfunction

  wire       fin     = (st != S_IDLE) && !mii_dv;
  wire [7:0] byte_in = {mii_rxd, lo};

  wire too_long = cnt > CNT_W'(MAX_LEN);
  wire wdog     = cnt > CNT_W'(WDOG_LEN);
  wire runt_hdr = cnt < CNT_W'(HDR_MIN);
  wire runt_min = cnt < CNT_W'(MIN_FRAME);
  wire typed    = !runt_hdr && (lt > 16'(TYPE_MAX));
  wire crc_bad  = crc != RESIDUE;
  wire crc_flag = !(runt_min || late || wdog) && (crc_bad || er_seen);
  wire dribble  = half && !late;

  wire [7:0] summary = {too_long, late, typed, wdog, er_seen, dribble, crc_flag, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      crc        <= '1;
      lt         <= '0;
      lo         <= '0;
      half       <= 1'b0;
      er_seen    <= 1'b0;
      late       <= 1'b0;
      stat_valid <= 1'b0;
      stat_byte  <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (fin) begin
        stat_valid <= 1'b1;
        stat_byte  <= summary;
        st         <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (mii_dv) begin
            cnt     <= '0;
            crc     <= '1;
            lt      <= '0;
            half    <= 1'b0;
            late    <= 1'b0;
            er_seen <= mii_er;
            st      <= (mii_rxd == SFD_NIB) ? S_DATA : S_PRE;
          end
          S_PRE: begin
            if (mii_er) er_seen <= 1'b1;
            if (mii_rxd == SFD_NIB) st <= S_DATA;
          end
          S_DATA: begin
            if (mii_er) er_seen <= 1'b1;
            if (mii_col && cnt >= CNT_W'(SLOT)) late <= 1'b1;
            if (!half) begin
              lo   <= mii_rxd;
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              crc  <= crc_byte(crc, byte_in);
              if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(LT_POS))     lt[15:8] <= byte_in;
              if (cnt == CNT_W'(LT_POS + 1)) lt[7:0]  <= byte_in;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_frame_classifier_chk.sv
module rx_frame_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mii_dv,
  input logic       stat_valid,
  input logic [7:0] stat_byte
);
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  p_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !$past(mii_dv));

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !stat_byte[0]);

  p_no_drib_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !(stat_byte[2] && stat_byte[6]));

  p_wdog_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_byte[4]) |-> stat_byte[7]);

  p_crc_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_byte[4] || stat_byte[6])) |-> !stat_byte[1]);
endmodule

bind rx_frame_classifier rx_frame_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mii_dv(mii_dv),
  .stat_valid(stat_valid), .stat_byte(stat_byte)
);

// File: tb/sim_rx_frame_classifier.sv
module sim_rx_frame_classifier;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0, dv = 0, er = 0, col = 0;
  logic [3:0] rxd = '0;
  logic stat_valid;
  logic [7:0] stat_byte;

  int tests = 0, fails = 0, pulses = 0;
  logic [7:0] fb [0:4095];

  always #(CLK_PER/2) clk = ~clk;

  rx_frame_classifier u0 (
    .clk(clk), .rst_n(rst_n), .mii_dv(dv), .mii_er(er), .mii_col(col),
    .mii_rxd(rxd), .stat_valid(stat_valid), .stat_byte(stat_byte)
  );

  always @(negedge clk) if (stat_valid) pulses++;

  typedef struct packed {
    int         len;
    logic [15:0] lt;
    int         er_n;
    int         col_n;
    bit         drib;
    bit         bad;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64,   16'h0800, -1,  -1,  1'b0, 1'b0, 8'h20},  // R4 R8
    '{64,   16'h05DC, -1,  -1,  1'b0, 1'b0, 8'h00},  // R4 R11
    '{64,   16'h05DD, -1,  -1,  1'b0, 1'b0, 8'h20},  // R4
    '{64,   16'h0800, -1,  -1,  1'b0, 1'b1, 8'h22},  // R8
    '{100,  16'h0800, 50,  -1,  1'b0, 1'b0, 8'h2A},  // R6 R9
    '{100,  16'h0040, -1,  -1,  1'b1, 1'b0, 8'h04},  // R7
    '{1518, 16'h0800, -1,  -1,  1'b0, 1'b0, 8'h20},  // R2
    '{1519, 16'h0800, -1,  -1,  1'b0, 1'b0, 8'hA0},  // R2
    '{2049, 16'h0800, -1,  -1,  1'b0, 1'b1, 8'hB0},  // R5 R10
    '{2048, 16'h0800, -1,  -1,  1'b0, 1'b1, 8'hA2},  // R5
    '{13,   16'h0800, -1,  -1,  1'b0, 1'b1, 8'h00},  // R4 R10
    '{63,   16'h0800, -1,  -1,  1'b0, 1'b1, 8'h20},  // R10
    '{100,  16'h0800, -1,  20,  1'b0, 1'b0, 8'h20},  // R3
    '{100,  16'h0800, -1,  140, 1'b1, 1'b1, 8'h60},  // R3 R7 R10
    '{20,   16'h0800, 4,   -1,  1'b0, 1'b0, 8'h28},  // R6 R10
    '{100,  16'h0800, -1,  127, 1'b0, 1'b0, 8'h20},  // R3
    '{100,  16'h0800, -1,  128, 1'b0, 1'b0, 8'h60}   // R3
  };

  function automatic logic [31:0] ref_fcs(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input int len, input logic [15:0] lt, input int er_n, input int col_n,
                      input bit drib, input bit bad, input int pre_n, input bit er_pre);
    logic [31:0] fcs;
    for (int i = 0; i < len; i++) fb[i] = 8'(i * 7 + 3);
    if (len > 12) fb[12] = lt[15:8];
    if (len > 13) fb[13] = lt[7:0];
    fcs = ref_fcs(len - 4);
    for (int j = 0; j < 4; j++) fb[len-4+j] = fcs[8*j +: 8];
    if (bad) fb[len-1] ^= 8'h01;
    pulses = 0;
    for (int p = 0; p < pre_n; p++) begin
      @(negedge clk); dv = 1; rxd = 4'h5; er = er_pre && (p == 1);
    end
    @(negedge clk); rxd = 4'hD; er = 0;
    for (int k = 0; k < 2*len + (drib ? 1 : 0); k++) begin
      @(negedge clk);
      if (k == 2*len) rxd = 4'hA;
      else rxd = k[0] ? fb[k/2][7:4] : fb[k/2][3:0];
      er  = (k == er_n);
      col = (k == col_n);
    end
    @(negedge clk); dv = 0; er = 0; col = 0; rxd = 0;
    check("R1 strobe low in drop cycle", {31'h0, stat_valid}, 32'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'h0, stat_valid}, 32'h0);
    check("R1 reset byte", {24'h0, stat_byte}, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VECS[v]) begin
      send(VECS[v].len, VECS[v].lt, VECS[v].er_n, VECS[v].col_n,
           VECS[v].drib, VECS[v].bad, 15, 1'b0);
      check($sformatf("vec %0d status R2..R11", v), {24'h0, stat_byte}, {24'h0, VECS[v].exp});
      check("R1 strobe high", {31'h0, stat_valid}, 32'h1);
      repeat (3) @(negedge clk);
      check("R1 single pulse", pulses, 1);
    end

    // R6: receive error inside the preamble, R9 forces CRC flag
    send(64, 16'h0800, -1, -1, 1'b0, 1'b0, 15, 1'b1);
    check("R6 er in preamble", {24'h0, stat_byte}, 32'h2A);
    repeat (2) @(negedge clk);

    // R11: clean frame right after an erroneous one
    send(64, 16'h0800, -1, -1, 1'b0, 1'b0, 15, 1'b0);
    check("R11 flags cleared", {24'h0, stat_byte}, 32'h20);
    repeat (2) @(negedge clk);

    // R12: short preamble, and SFD as the very first nibble
    send(64, 16'h0900, -1, -1, 1'b0, 1'b0, 3, 1'b0);
    check("R12 short preamble", {24'h0, stat_byte}, 32'h20);
    repeat (2) @(negedge clk);
    send(64, 16'h0900, -1, -1, 1'b0, 1'b0, 0, 1'b0);
    check("R12 no preamble", {24'h0, stat_byte}, 32'h20);
    repeat (2) @(negedge clk);

    // R11: reset mid-frame gives no status
    pulses = 0;
    repeat (10) begin @(negedge clk); dv = 1; rxd = 4'h5; end
    rst_n = 0;
    @(negedge clk); dv = 0; rst_n = 1;
    repeat (4) @(negedge clk);
    check("R11 no strobe after mid-frame reset", pulses, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule